// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32768 Hz tick enable into a periodic event whose rate is set by a 4-bit rate code held in a control register. Each rate code selects a power-of-two number of ticks. The two smallest non-zero codes are moved up to slower rates, and code zero switches the function off. A 16-bit tick counter runs freely from reset. An event fires on the tick that brings this counter to a whole multiple of the selected period. Because of this, a change of rate or enable is picked up on the very next tick and lands on the next aligned boundary, not one full period after the change.

Two enables gate the outputs. When the interrupt enable is set, a boundary gives a one-clock event pulse and latches two flags in an 8-bit status byte: the interrupt-request flag in bit 7 and the periodic flag in bit 6. The interrupt line follows the request flag. When the square-wave enable is set, a boundary gives a one-clock pulse on the square-wave output instead of a level toggle. The flags stay set until the status byte is read, which the host signals with a clear strobe.

Top module: `periodic_irq_gen`

## Requirements
- R1: Synchronous active-high reset clears the tick counter, both pulses and both flags. After reset, the first boundary falls on tick number P, where P is the period.
- R2: A rate code of 0 produces no event pulse and no square-wave pulse, whatever the enables are.
- R3: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks.
- R4: Rate codes 3 through 15 give a period of 2^(code-1) ticks, for example 4 ticks for code 3 and 16384 ticks for code 15.
- R5: With both the interrupt enable and the square-wave enable clear, no pulse is produced.
- R6: A boundary is the tick on which the free-running 16-bit tick count becomes a multiple of P. A change of rate code takes effect on the next tick, so the next event falls on the next multiple of the new period.
- R7: A boundary with the interrupt enable set raises `per_evt` for exactly one clock, in the cycle after the clock edge that took the tick.
- R8: The same boundary sets status bit 7 (interrupt request) and bit 6 (periodic flag); all other status bits read 0. The flags hold until `flag_clr` is pulsed. If a new boundary and a clear happen in the same cycle, the set wins.
- R9: A boundary with the square-wave enable set raises `sqw_pulse` for one clock. This is independent of the interrupt enable, and the pulse does not touch the flags.
- R10: `irq` is high exactly when status bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock enable at 32768 Hz |
| rate_code | input | 4 | Rate select from the control register |
| pie | input | 1 | Periodic interrupt enable |
| sqwe | input | 1 | Square-wave output enable |
| flag_clr | input | 1 | Status-read strobe that clears the flags |
| per_evt | output | 1 | One-clock periodic event |
| sqw_pulse | output | 1 | One-clock square-wave pulse |
| irq | output | 1 | Interrupt line, follows the request flag |
| status | output | 8 | Status byte: bit 7 request flag, bit 6 periodic flag |

## Verification
The fast code 3, the remapped codes 1 and 2, and the slowest code 15 are run tick by tick. This separates the remapping from the plain power-of-two rule and exposes any mask that is too short for the wide periods. A switch from a 32-tick period to a 4-tick period in the middle of a period shows whether the next event lands on the next aligned count or a full period after the change. Runs with code zero, with both enables off, and with only the square-wave enable on separate the gating of the pulses from the setting of the flags. A clear that coincides with a boundary checks which of the two wins.

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int CNT_W       = 16,
  parameter int RATE_W      = 4,
  parameter int REMAP_LIMIT = 2,
  parameter int REMAP_ADD   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              pie,
  input  logic              sqwe,
  input  logic              flag_clr,
  output logic              per_evt,
  output logic              sqw_pulse,
  output logic              irq,
  output logic [7:0]        status
);

  localparam logic [RATE_W:0] ADD_V = (RATE_W+1)'(REMAP_ADD);
  localparam logic [RATE_W:0] LIM_V = (RATE_W+1)'(REMAP_LIMIT);

  logic [CNT_W-1:0] cnt, cnt_nx, mask;
  logic [RATE_W:0]  code_w, eff;
  logic             active, hit, irqf, pf;

  assign code_w = {1'b0, rate_code};
  assign eff    = (code_w != '0 && code_w <= LIM_V) ? code_w + ADD_V : code_w;
  assign active = (rate_code != '0) && (pie || sqwe);
  assign cnt_nx = cnt + CNT_W'(1);

  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      mask[i] = (i < int'(eff) - 1);
  end

  assign hit = tick && active && ((cnt_nx & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      per_evt   <= 1'b0;
      sqw_pulse <= 1'b0;
      irqf      <= 1'b0;
      pf        <= 1'b0;
    end else begin
      if (tick) cnt <= cnt_nx;
      per_evt   <= hit && pie;
      sqw_pulse <= hit && sqwe;
      if (hit && pie) begin
        irqf <= 1'b1;
        pf   <= 1'b1;
      end else if (flag_clr) begin
        irqf <= 1'b0;
        pf   <= 1'b0;
      end
    end
  end

  assign status = {irqf, pf, 6'b0};
  assign irq    = irqf;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && !per_evt && !sqw_pulse && status == 8'h00));

  // R2
  off_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> (!per_evt && !sqw_pulse));

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (!pie && !sqwe) |=> (!per_evt && !sqw_pulse));

  // R6
  evt_align_chk: assert property (@(posedge clk) disable iff (rst)
    (per_evt || sqw_pulse) |-> ((cnt & $past(mask)) == '0));

  // R7
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    per_evt |=> !per_evt);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[6] && !flag_clr) |=> status[6]);

  // R9
  sqw_single_chk: assert property (@(posedge clk) disable iff (rst)
    sqw_pulse |=> !sqw_pulse);

endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
  logic clk = 0, rst = 1, tick = 0, pie = 0, sqwe = 0, flag_clr = 0;
  logic [3:0] code = 0;
  logic per_evt, sqw_pulse, irq;
  logic [7:0] status;
  int total = 0, bad = 0, mcnt = 0, evts = 0;
  bit mf = 0;

  always #4 clk = ~clk;

  periodic_irq_gen dut (.clk(clk), .rst(rst), .tick(tick), .rate_code(code),
    .pie(pie), .sqwe(sqwe), .flag_clr(flag_clr), .per_evt(per_evt),
    .sqw_pulse(sqw_pulse), .irq(irq), .status(status));

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at mcnt=%0d", r, act, exp, mcnt);
    end
  endtask

  function automatic int per_of(int c);
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 1 << (c - 1);
  endfunction

  task automatic tick_once(bit clr, string r);
    int p;
    bit h;
    p = per_of(int'(code));
    h = (p != 0) && (pie || sqwe) && ((((mcnt + 1) & 16'hFFFF) % p) == 0);
    @(negedge clk); tick = 1; flag_clr = clr;
    @(negedge clk); tick = 0; flag_clr = 0;
    mcnt = (mcnt + 1) & 16'hFFFF;
    if (h && pie) mf = 1; else if (clr) mf = 0;
    if (h && pie) evts++;
    chk(per_evt == (h && pie), r, per_evt, h && pie);
    chk(sqw_pulse == (h && sqwe), {r, "/R9"}, sqw_pulse, h && sqwe);
    chk(status == {mf, mf, 6'b0}, {r, "/R8"}, status, {mf, mf, 6'b0});
    chk(irq == mf, {r, "/R10"}, irq, mf);
    if (h) begin
      @(negedge clk);
      chk(!per_evt && !sqw_pulse, {r, "/R7"}, {per_evt, sqw_pulse}, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; mcnt = 0; mf = 0;
    @(negedge clk);
    chk(status == 8'h00 && !per_evt && !sqw_pulse && !irq, "R1", status, 0);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; mf = 0;
    chk(status == 8'h00 && !irq, "R8", status, 0);
  endtask

  task automatic t_fast();
    code = 3; pie = 1; sqwe = 0; evts = 0;
    for (int i = 0; i < 16; i++) tick_once(0, "R4");
    chk(evts == 4, "R4", evts, 4);
  endtask

  task automatic t_remap();
    code = 1; pie = 1;
    for (int i = 0; i < 256; i++) tick_once(0, "R3");
    code = 2;
    for (int i = 0; i < 300; i++) tick_once(0, "R3");
  endtask

  task automatic t_realign();
    int n;
    code = 6; pie = 1; sqwe = 0;
    while ((mcnt % 4) != 1 || (mcnt % 32) < 4) tick_once(0, "R6");
    code = 3; evts = 0; n = 0;
    while (evts == 0 && n < 10) begin tick_once(0, "R6"); n++; end
    chk(n == 3, "R6", n, 3);
  endtask

  task automatic t_off();
    code = 0; pie = 1; sqwe = 1;
    for (int i = 0; i < 64; i++) tick_once(0, "R2");
  endtask

  task automatic t_noen();
    code = 3; pie = 0; sqwe = 0;
    for (int i = 0; i < 32; i++) tick_once(0, "R5");
  endtask

  task automatic t_sqw();
    clear_flags();
    code = 4; pie = 0; sqwe = 1;
    for (int i = 0; i < 40; i++) tick_once(0, "R9");
    chk(status == 8'h00, "R9", status, 0);
  endtask

  task automatic t_flags();
    code = 3; pie = 1; sqwe = 0;
    while ((mcnt % 4) != 2) tick_once(0, "R8");
    tick_once(0, "R8");
    for (int i = 0; i < 2; i++) tick_once(0, "R8");
    chk(status == 8'hC0 && irq, "R8", status, 8'hC0);
    clear_flags();
    tick_once(0, "R8");
    tick_once(0, "R8");
    tick_once(0, "R8");
    clear_flags();
    while ((mcnt % 4) != 3) tick_once(0, "R8");
    tick_once(1, "R8");
    chk(status == 8'hC0, "R8", status, 8'hC0);
  endtask

  task automatic t_slow();
    code = 15; pie = 1; sqwe = 1; evts = 0;
    while (evts == 0) tick_once(0, "R4");
    chk(mcnt % 16384 == 0, "R4", mcnt, 16384);
  endtask

  task automatic t_rst_mid();
    code = 3; pie = 1; sqwe = 0;
    tick_once(0, "R1");
    do_reset();
    evts = 0;
    for (int i = 0; i < 3; i++) tick_once(0, "R1");
    chk(evts == 0, "R1", evts, 0);
    tick_once(0, "R1");
    chk(evts == 1, "R1", evts, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_fast();
    t_remap();
    t_realign();
    t_off();
    t_noen();
    t_sqw();
    t_flags();
    t_slow();
    t_rst_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule